// File: doc/BRIEF.md
# SONET Framing Word Aligner

This block sits after a deserializer that delivers an 8-bit parallel stream with an arbitrary bit phase. It looks for the SONET/SDH framing bytes at every one of the eight possible bit offsets. Once it finds them, it turns the stream into byte-aligned data. The bit order on the wire is fixed: `din[7]` is the earliest bit of each input byte, and the stream continues from bit 0 of one byte into bit 7 of the next.

The framing pattern is programmed as a 16-bit parameter. Its upper byte is the first framing byte and its lower byte is the second. A run-time select chooses between matching the two bytes once (short form) and matching each byte twice in a row (long form). A second input bit-reverses the programmed word before comparison, so either transmission bit order can be served from one setting. A parameter can tie the block to the long form for the fastest line rates.

After lock, the selected offset stays fixed until software or a supervisor raises the realign input. A one-cycle marker shows where each framing pattern ends in the aligned output, which downstream frame logic can use.

Top module: `frame_word_aligner`

## Requirements
- R1: At lock offset k, the output byte for input byte j is {low k bits of byte j-1, high 8-k bits of byte j}, where the byte j-1 bits are the more significant. The offset k is counted from the end of the newest byte.
- R2: Output data, the valid flag and the pattern marker appear exactly two clocks after the input byte they belong to.
- R3: With `long_sel` low, the search matches 16 consecutive stream bits against the effective word E. The earliest bit is compared with E[15].
- R4: With `long_sel` high, the search matches 32 bits against {E[15:8], E[15:8], E[7:0], E[7:0]}. A lone 16-bit E then causes no lock.
- R5: With `flip_pat` high, E is the full 16-bit bit-reversal of `SYNC_WORD`; with it low, E equals `SYNC_WORD`. A non-reversed word gives no lock while reversal is on.
- R6: With parameter `LONG_ONLY` set, the block always uses the 32-bit form, whatever the value of `long_sel`.
- R7: While the search is armed, the first match at any offset locks that offset. `sync_ok` and `dout_vld` then go high together with the output byte that completes the pattern. If several offsets match at once, the lowest offset wins.
- R8: While locked, patterns at other offsets are ignored. The output stays at the locked offset, and `sync_ok` stays high.
- R9: A rising edge on `realign` clears `sync_ok` and re-arms the search. Holding `realign` high re-arms the search only once.
- R10: A match in the window that the rising edge of `realign` is sampled against is honoured, so the block locks again at once at that match's offset.
- R11: `frame_hit` pulses for one cycle with each output byte that completes the pattern at the locked offset, including the byte that acquires lock. It is never high without `sync_ok`.
- R12: During reset, `dout` is 0, `sync_ok`, `dout_vld` and `frame_hit` are 0, and the search is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | BYTE_W | Unaligned stream byte, bit 7 earliest |
| long_sel | input | 1 | 0: two-byte pattern, 1: four-byte pattern |
| flip_pat | input | 1 | Bit-reverse the programmed word before compare |
| realign | input | 1 | Rising edge drops lock and re-arms the search |
| dout | output | BYTE_W | Byte-aligned data |
| dout_vld | output | 1 | Output data is aligned (follows sync state) |
| sync_ok | output | 1 | Lock status |
| frame_hit | output | 1 | Output byte completes a pattern at the locked offset |

## Verification
The hardest case to reach is a realign edge that arrives in the very cycle the window holds a complete pattern, because it depends on which bit offset the stimulus used. The bench therefore builds the input as a bit stream and places each pattern at a chosen offset. It knows the byte in which the pattern ends and raises `realign` with the next byte, so that the edge and the match coincide. It also holds `realign` high across two patterns at different offsets, to show that only the edge re-arms the search.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

  typedef enum logic {
    FWA_SHORT = 1'b0,
    FWA_LONG  = 1'b1
  } fwa_len_e;

  typedef struct packed {
    logic sync;
    logic armed;
  } fwa_state_t;

endpackage

// File: rtl/fwa_pattern.sv
module fwa_pattern
  import fwa_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter logic [15:0] SYNC_WORD = 16'hF628,
  parameter bit          LONG_ONLY = 1'b0
) (
  input  logic                  flip_pat,
  input  logic                  long_sel,
  output logic [4*BYTE_W-1:0]   pat_word,
  output fwa_len_e              pat_len
);

  localparam int PW = 2 * BYTE_W;

  logic [PW-1:0] word_rev;
  logic [PW-1:0] word_eff;
  logic [BYTE_W-1:0] first_b;
  logic [BYTE_W-1:0] second_b;

  // full-width bit reversal of the programmed word
  for (genvar i = 0; i < PW; i++) begin : g_rev
    assign word_rev[i] = SYNC_WORD[PW-1-i];
  end

  always_comb begin
    word_eff = flip_pat ? word_rev : SYNC_WORD[PW-1:0];
    first_b  = word_eff[PW-1 -: BYTE_W];
    second_b = word_eff[BYTE_W-1:0];
    pat_word = {first_b, first_b, second_b, second_b};
    pat_len  = (LONG_ONLY || long_sel) ? FWA_LONG : FWA_SHORT;
  end

endmodule

// File: rtl/fwa_search.sv
module fwa_search
  import fwa_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BYTE_W-1:0]     din,
  input  logic [4*BYTE_W-1:0]   pat_word,
  input  fwa_len_e              pat_len,
  output logic [2*BYTE_W-2:0]   near_win,
  output logic [BYTE_W-1:0]     hit_vec
);

  localparam int WIN_W = 5 * BYTE_W - 1;
  localparam int SW    = 2 * BYTE_W;
  localparam int LW    = 4 * BYTE_W;

  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_d;
  logic [SW-1:0]    short_pat;

  always_comb begin
    win_d     = {win_q[WIN_W-1-BYTE_W:0], din};
    short_pat = pat_word[3*BYTE_W-1:BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  // one comparator pair per bit offset, all evaluated every clock
  for (genvar k = 0; k < BYTE_W; k++) begin : g_off
    logic m_short;
    logic m_long;
    assign m_short  = (win_q[k +: SW] == short_pat);
    assign m_long   = (win_q[k +: LW] == pat_word);
    assign hit_vec[k] = (pat_len == FWA_LONG) ? m_long : m_short;
  end

  assign near_win = win_q[2*BYTE_W-2:0];

endmodule

// File: rtl/fwa_lock.sv
module fwa_lock
  import fwa_pkg::*;
#(
  parameter int OFF_N = 8,
  parameter int OFF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             realign,
  input  logic [OFF_N-1:0] hit_vec,
  output logic [OFF_W-1:0] sel_off,
  output logic             sync_d,
  output logic             sync_q
);

  fwa_state_t       st_q, st_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             off_en;
  logic             rl_q;
  logic             rise;
  logic             any_hit;
  logic             take;
  logic             armed_eff;
  logic [OFF_W-1:0] first_off;

  // next-state logic
  always_comb begin
    first_off = '0;
    any_hit   = 1'b0;
    for (int i = OFF_N - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        first_off = OFF_W'(i);
        any_hit   = 1'b1;
      end
    end
    rise      = realign & ~rl_q;
    armed_eff = st_q.armed | rise;
    take      = armed_eff & any_hit;
    off_en    = take;
    off_d     = first_off;
    st_d.armed = take ? 1'b0 : armed_eff;
    if (take)      st_d.sync = 1'b1;
    else if (rise) st_d.sync = 1'b0;
    else           st_d.sync = st_q.sync;
    sel_off = take ? first_off : off_q;
    sync_d  = st_d.sync;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.sync  <= 1'b0;
      st_q.armed <= 1'b1;
      rl_q       <= 1'b0;
    end else begin
      st_q <= st_d;
      rl_q <= realign;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign sync_q = st_q.sync;

endmodule

// File: rtl/fwa_align_out.sv
module fwa_align_out #(
  parameter int BYTE_W = 8,
  parameter int OFF_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*BYTE_W-2:0] near_win,
  input  logic [BYTE_W-1:0]   hit_vec,
  input  logic [OFF_W-1:0]    sel_off,
  input  logic                sync_d,
  output logic [BYTE_W-1:0]   dout,
  output logic                frame_hit
);

  logic [BYTE_W-1:0] dout_d;
  logic              hit_d;

  always_comb begin
    dout_d = BYTE_W'(near_win >> sel_off);
    hit_d  = sync_d & hit_vec[sel_off];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= '0;
      frame_hit <= 1'b0;
    end else begin
      dout      <= dout_d;
      frame_hit <= hit_d;
    end
  end

endmodule

// File: rtl/frame_word_aligner.sv
module frame_word_aligner
  import fwa_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter logic [15:0] SYNC_WORD = 16'hF628,
  parameter bit          LONG_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] din,
  input  logic              long_sel,
  input  logic              flip_pat,
  input  logic              realign,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_vld,
  output logic              sync_ok,
  output logic              frame_hit
);

  localparam int OFF_N = BYTE_W;
  localparam int OFF_W = $clog2(BYTE_W);

  logic [4*BYTE_W-1:0] pat_word;
  fwa_len_e            pat_len;
  logic [2*BYTE_W-2:0] near_win;
  logic [OFF_N-1:0]    hit_vec;
  logic [OFF_W-1:0]    sel_off_w;
  logic                sync_d;
  logic                sync_q;

  fwa_pattern #(
    .BYTE_W(BYTE_W), .SYNC_WORD(SYNC_WORD), .LONG_ONLY(LONG_ONLY)
  ) u_pat (
    .flip_pat(flip_pat), .long_sel(long_sel),
    .pat_word(pat_word), .pat_len(pat_len)
  );

  fwa_search #(.BYTE_W(BYTE_W)) u_search (
    .clk(clk), .rst_n(rst_n), .din(din),
    .pat_word(pat_word), .pat_len(pat_len),
    .near_win(near_win), .hit_vec(hit_vec)
  );

  fwa_lock #(.OFF_N(OFF_N), .OFF_W(OFF_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .realign(realign), .hit_vec(hit_vec),
    .sel_off(sel_off_w), .sync_d(sync_d), .sync_q(sync_q)
  );

  fwa_align_out #(.BYTE_W(BYTE_W), .OFF_W(OFF_W)) u_out (
    .clk(clk), .rst_n(rst_n), .near_win(near_win), .hit_vec(hit_vec),
    .sel_off(sel_off_w), .sync_d(sync_d),
    .dout(dout), .frame_hit(frame_hit)
  );

  assign sync_ok  = sync_q;
  assign dout_vld = sync_q;

endmodule

// File: rtl/fwa_checker.sv
module fwa_checker #(
  parameter int BYTE_W = 8,
  parameter int OFF_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              realign,
  input logic              sync_ok,
  input logic              dout_vld,
  input logic              frame_hit,
  input logic [BYTE_W-1:0] dout,
  input logic [OFF_W-1:0]  sel_off
);

  // R12: reset holds outputs quiet
  a_r12_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!sync_ok && !dout_vld && !frame_hit && dout == '0));

  // R11: marker only while synchronised
  a_r11_hit_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hit |-> dout_vld);

  // R8: lock persists without a realign edge
  a_r8_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && !$rose(realign)) |=> sync_ok);

  // R8: locked offset does not move without a realign edge
  a_r8_offset_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && !$rose(realign)) ##1 !$rose(realign) |-> $stable(sel_off));

  // R9 / R10: an edge drops lock unless a match is taken in the same cycle
  a_r9_realign_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(realign) |=> (!sync_ok || frame_hit));

endmodule

bind frame_word_aligner fwa_checker #(.BYTE_W(BYTE_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .realign(realign), .sync_ok(sync_ok),
  .dout_vld(dout_vld), .frame_hit(frame_hit), .dout(dout), .sel_off(sel_off_w)
);

// File: tb/frame_word_aligner_test.sv
module frame_word_aligner_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [7:0] din;
  logic       long_sel, flip_pat, realign;
  logic [7:0] dout, l_dout;
  logic       dout_vld, sync_ok, frame_hit;
  logic       l_vld, l_sync, l_hit;

  frame_word_aligner uut (
    .clk(clk), .rst_n(rst_n), .din(din), .long_sel(long_sel), .flip_pat(flip_pat),
    .realign(realign), .dout(dout), .dout_vld(dout_vld), .sync_ok(sync_ok),
    .frame_hit(frame_hit)
  );

  frame_word_aligner #(.LONG_ONLY(1'b1)) uut_long (
    .clk(clk), .rst_n(rst_n), .din(din), .long_sel(long_sel), .flip_pat(flip_pat),
    .realign(realign), .dout(l_dout), .dout_vld(l_vld), .sync_ok(l_sync),
    .frame_hit(l_hit)
  );

  int nchk = 0;
  int nfail = 0;
  int n = 0;
  int accn = 0;
  int last_end = 0;
  logic [7:0] acc = 8'h00;
  logic       rl_next = 1'b0;
  logic [7:0] sent   [0:4095];
  logic [7:0] o_dout [0:4095];
  logic       o_vld  [0:4095];
  logic       o_hit  [0:4095];
  logic       o_lvld [0:4095];
  logic       o_lhit [0:4095];

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [7:0] exp_byte(input int j, input int k);
    logic [15:0] pair;
    pair = {sent[j-1], sent[j]};
    return 8'(pair >> k);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one byte; outputs seen now belong to byte n-2
  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    if (n >= 2) begin
      o_dout[n-2] = dout;
      o_vld[n-2]  = dout_vld;
      o_hit[n-2]  = frame_hit;
      o_lvld[n-2] = l_vld;
      o_lhit[n-2] = l_hit;
    end
    realign = rl_next;
    din     = b;
    sent[n] = b;
    n++;
  endtask

  task automatic put_bit(input logic b);
    acc = {acc[6:0], b};
    accn++;
    if (accn == 8) begin
      push_byte(acc);
      accn = 0;
    end
  endtask

  task automatic put_bits(input logic [31:0] v, input int len);
    for (int i = len - 1; i >= 0; i--) put_bit(v[i]);
  endtask

  // place a pattern so that it ends k bits before a byte boundary
  task automatic send_at(input int k, input logic [31:0] v, input int len);
    while (accn != (8 - k) % 8) put_bit(1'b0);
    put_bits(v, len);
    last_end = (accn == 0) ? n - 1 : n;
    while (accn != 0) put_bit(1'b0);
    repeat (3) put_bits(32'h0, 8);
  endtask

  task automatic rearm();
    int r;
    r = n;
    rl_next = 1'b1;
    put_bits(32'h0, 8);
    rl_next = 1'b0;
    put_bits(32'h0, 8);
    chk("R9", "sync after realign edge", 32'(o_vld[r-1]), 32'h0);
  endtask

  task automatic t_acquire(input string req, input int k, input logic [31:0] v, input int len);
    rearm();
    send_at(k, v, len);
    chk(req, "vld before pattern end", 32'(o_vld[last_end-1]), 32'h0);
    chk(req, "vld at pattern end", 32'(o_vld[last_end]), 32'h1);
    chk(req, "hit at pattern end", 32'(o_hit[last_end]), 32'h1);
    chk(req, "dout at pattern end", 32'(o_dout[last_end]), 32'(exp_byte(last_end, k)));
    chk(req, "dout after pattern", 32'(o_dout[last_end+1]), 32'(exp_byte(last_end+1, k)));
    chk(req, "hit after pattern", 32'(o_hit[last_end+1]), 32'h0);
  endtask

  task automatic t_no_lock(input string req, input int k, input logic [31:0] v, input int len);
    rearm();
    send_at(k, v, len);
    chk(req, "no lock at end", 32'(o_vld[last_end]), 32'h0);
    chk(req, "no lock after end", 32'(o_vld[last_end+1]), 32'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; din = 8'h00; long_sel = 1'b0; flip_pat = 1'b0; realign = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12", "dout in reset", 32'(dout), 32'h0);
    chk("R12", "sync in reset", 32'(sync_ok), 32'h0);
    chk("R12", "vld in reset", 32'(dout_vld), 32'h0);
    chk("R12", "hit in reset", 32'(frame_hit), 32'h0);
    rst_n = 1'b1;
    repeat (4) put_bits(32'h0, 8);
  endtask

  task automatic t_hold();
    t_acquire("R8", 2, 32'hF628, 16);
    send_at(6, 32'hF628, 16);
    chk("R8", "sync kept on foreign offset", 32'(o_vld[last_end]), 32'h1);
    chk("R8", "no hit on foreign offset", 32'(o_hit[last_end]), 32'h0);
    chk("R8", "dout stays on offset 2", 32'(o_dout[last_end]), 32'(exp_byte(last_end, 2)));
    send_at(2, 32'hF628, 16);
    chk("R11", "hit on repeat at locked offset", 32'(o_hit[last_end]), 32'h1);
    chk("R11", "hit is one cycle", 32'(o_hit[last_end+1]), 32'h0);
    chk("R11", "hit one cycle earlier low", 32'(o_hit[last_end-1]), 32'h0);
  endtask

  task automatic t_level();
    int r;
    r = n;
    rl_next = 1'b1;
    put_bits(32'h0, 8);
    put_bits(32'h0, 8);
    chk("R9", "edge clears sync", 32'(o_vld[r-1]), 32'h0);
    send_at(4, 32'hF628, 16);
    chk("R9", "relock after edge", 32'(o_vld[last_end]), 32'h1);
    send_at(1, 32'hF628, 16);
    chk("R9", "held level does not rearm", 32'(o_hit[last_end]), 32'h0);
    chk("R9", "held level keeps offset 4", 32'(o_dout[last_end]), 32'(exp_byte(last_end, 4)));
    rl_next = 1'b0;
    put_bits(32'h0, 8);
  endtask

  task automatic t_same_cycle();
    int e;
    t_acquire("R10", 6, 32'hF628, 16);
    put_bits(32'hF628, 16);
    e = n - 1;
    rl_next = 1'b1;
    put_bits(32'h0, 8);
    rl_next = 1'b0;
    repeat (3) put_bits(32'h0, 8);
    chk("R10", "sync with coincident match", 32'(o_vld[e]), 32'h1);
    chk("R10", "hit with coincident match", 32'(o_hit[e]), 32'h1);
    chk("R10", "new offset 0 data", 32'(o_dout[e+1]), 32'(exp_byte(e+1, 0)));
  endtask

  task automatic t_long_only();
    long_sel = 1'b0;
    rearm();
    send_at(3, 32'hF628, 16);
    chk("R6", "long-only ignores short pattern", 32'(o_lvld[last_end]), 32'h0);
    chk("R6", "long-only ignores short pattern next", 32'(o_lvld[last_end+1]), 32'h0);
    rearm();
    send_at(0, 32'hF6F62828, 32);
    chk("R6", "long-only locks on long pattern", 32'(o_lvld[last_end]), 32'h1);
    chk("R6", "long-only hit on long pattern", 32'(o_lhit[last_end]), 32'h1);
  endtask

  initial begin
    t_reset();
    for (int k = 0; k < 8; k++) t_acquire("R1 R2 R3 R7", k, 32'hF628, 16);
    long_sel = 1'b1;
    t_acquire("R4", 3, 32'hF6F62828, 32);
    t_no_lock("R4", 0, 32'hF628, 16);
    long_sel = 1'b0;
    flip_pat = 1'b1;
    t_acquire("R5", 5, 32'(rev16(16'hF628)), 16);
    t_no_lock("R5", 5, 32'hF628, 16);
    flip_pat = 1'b0;
    t_hold();
    t_level();
    t_same_cycle();
    t_long_only();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule